// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit side of a classic byte-wide serial port. A host writes one byte into a single-entry holding register. The block moves that byte into a shift register and sends it on the serial line as one frame: a low start bit, five to eight data bits with the least significant bit first, an optional parity bit, and one, one-and-a-half or two high stop bits. A line-control byte chooses the frame shape. The block takes a snapshot of it, together with the data, when a frame is loaded. A break control drives the line low at any time while it is set.

Bit timing comes from a baud tick that pulses once per sixteenth of a bit. The divisor that makes this tick is outside the block, and so are any receiver and any queueing. The block reports two status bits. Holding-empty means the host may write again. Transmitter-empty means nothing is waiting and nothing is being shifted. A byte written while a frame is going out waits in the holding register. Its start bit begins on the tick that ends the current frame's stop time.

Top module: `sertx_top`

## Requirements
- R1: After reset the serial line is high (marking), and holding-empty and transmitter-empty both read 1.
- R2: A frame is a low start bit, then the data bits least significant first, then the stop time at high level. Start, data and parity bits each last TICKS_PER_BIT baud ticks.
- R3: Line-control bits [1:0] set the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length are never sent.
- R4: Line-control bit 3 adds a parity bit after the data. With bit 4 set, the parity makes the count of ones in data plus parity even. With bit 4 clear, it makes that count odd.
- R5: With parity enabled and line-control bit 5 set, the parity bit is the complement of bit 4: it is 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R6: With line-control bit 2 clear the stop time is one bit (16 ticks). With bit 2 set it is two bits (32 ticks), except for a 5-bit word, where it is 24 ticks.
- R7: While line-control bit 6 is set, the serial line is low from the next clock on. When the bit clears, the line shows the transmitter's level again.
- R8: Holding-empty falls in the clock after a host write. It rises again when the shifter takes the byte: one clock later if the shifter is idle, or at the end of the current frame otherwise.
- R9: Transmitter-empty is 1 only when the holding register is empty and no frame is in progress.
- R10: A byte held while a frame is in progress starts its start bit on the same tick that ends the previous stop time, with no idle time between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse, TICKS_PER_BIT per bit time |
| lcr | input | 8 | Line-control byte (fields as in R3 to R7; bit 7 unused) |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line, idle high |
| thr_empty | output | 1 | Holding register may be written |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
The bench builds the block with the default TICKS_PER_BIT of 16 and sends a baud tick every fourth clock. With these values each frame's bits can be sampled at the middle of each bit, counted in ticks. The full frame length can be counted exactly, so the 24-tick stop time that 5-bit words use is distinguishable from both 16 and 32. The tick spacing also leaves several clocks between ticks. This makes the one-clock load of an idle shifter and the hand-over at the end of a frame visible at the status outputs.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int LC_W     = 8;
  localparam int WORD_MAX = 8;
  localparam int WORD_MIN = 5;

  // line-control field positions
  localparam int LC_LEN   = 0;  // two bits
  localparam int LC_STOP  = 2;
  localparam int LC_PEN   = 3;
  localparam int LC_EVEN  = 4;
  localparam int LC_STICK = 5;
  localparam int LC_BRK   = 6;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [3:0] nbits;     // 5..8
    logic       par_en;
    logic       par_val;
    logic       long_stop; // two bit times
    logic       half_stop; // one and a half bit times
  } frame_cfg_t;

endpackage

// File: rtl/sertx_holding.sv
module sertx_holding
  import sertx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_MAX-1:0] wr_data,
  input  logic                take,
  output logic                full,
  output logic [WORD_MAX-1:0] data
);

  logic                full_q, full_d;
  logic [WORD_MAX-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (wr_en) data_d = wr_data;
    if (take) full_d = wr_en;
    else      full_d = full_q | wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R8: a write always leaves a byte waiting
  a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full_q);

  // R8: the shifter only takes a byte that is present
  a_r8_take_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  logic [LC_W-1:0]     lcr,
  input  logic [WORD_MAX-1:0] data,
  output frame_cfg_t          cfg,
  output logic [WORD_MAX-1:0] data_masked
);

  logic [1:0]          len_code;
  logic [WORD_MAX-1:0] mask;
  logic                ones_odd;

  always_comb begin
    len_code = lcr[LC_LEN +: 2];
    for (int i = 0; i < WORD_MAX; i++) begin
      mask[i] = (i < (WORD_MIN + int'(len_code)));
    end
    data_masked = data & mask;
    ones_odd    = ^data_masked;

    cfg.nbits  = 4'(WORD_MIN) + {2'b00, len_code};
    cfg.par_en = lcr[LC_PEN];
    if (lcr[LC_STICK])     cfg.par_val = ~lcr[LC_EVEN];
    else if (lcr[LC_EVEN]) cfg.par_val = ones_odd;
    else                   cfg.par_val = ~ones_odd;
    cfg.long_stop = lcr[LC_STOP] && (len_code != 2'b00);
    cfg.half_stop = lcr[LC_STOP] && (len_code == 2'b00);
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic                hold_valid,
  input  logic [WORD_MAX-1:0] hold_data,
  input  frame_cfg_t          cfg_in,
  input  logic                brk,
  output logic                load,
  output logic                busy,
  output logic                line
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

  tx_state_e           state_q, state_d;
  logic [CNT_W-1:0]    tick_q, tick_d;
  logic [2:0]          idx_q, idx_d;
  logic [WORD_MAX-1:0] sh_q, sh_d;
  frame_cfg_t          cfg_q, cfg_d;
  logic                line_q, line_d;
  logic [CNT_W-1:0]    stop_last;
  logic [CNT_W-1:0]    bit_last;
  logic                bit_end;

  always_comb begin
    if (cfg_q.long_stop)      stop_last = LAST_TWO;
    else if (cfg_q.half_stop) stop_last = LAST_HALF;
    else                      stop_last = LAST_ONE;
    bit_last = (state_q == ST_STOP) ? stop_last : LAST_ONE;
    bit_end  = baud_tick && (tick_q == bit_last);
  end

  // next-state
  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    cfg_d   = cfg_q;
    load    = 1'b0;

    if (baud_tick && state_q != ST_IDLE) begin
      tick_d = bit_end ? '0 : tick_q + 1'b1;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (hold_valid) load = 1'b1;
      end
      ST_START: begin
        if (bit_end) begin
          state_d = ST_DATA;
          idx_d   = '0;
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          sh_d = sh_q >> 1;
          if ({1'b0, idx_q} == cfg_q.nbits - 4'd1) begin
            state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_PAR: begin
        if (bit_end) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (bit_end) begin
          if (hold_valid) load = 1'b1;
          else            state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (load) begin
      state_d = ST_START;
      tick_d  = '0;
      idx_d   = '0;
      sh_d    = hold_data;
      cfg_d   = cfg_in;
    end

    unique case (state_d)
      ST_START: line_d = 1'b0;
      ST_DATA:  line_d = sh_d[0];
      ST_PAR:   line_d = cfg_d.par_val;
      default:  line_d = 1'b1;
    endcase
    if (brk) line_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      cfg_q   <= '0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      cfg_q   <= cfg_d;
      line_q  <= line_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign line = line_q;

  // R7: break pulls the line low on the next clock
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !line_q);

  // R2: every loaded frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !line_q);

  // R2: the line marks high while nothing is sent and no break is set
  a_r2_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (state_d == ST_IDLE && !brk) |=> line_q);

  // R6: the stop counter never runs past the selected stop length
  a_r6_stop_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (tick_q <= stop_last));

  // R3: the data index stays inside the chosen word length
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> ({1'b0, idx_q} < cfg_q.nbits));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                baud_tick,
  input  logic [LC_W-1:0]     lcr,
  input  logic                wr_en,
  input  logic [WORD_MAX-1:0] wr_data,
  output logic                txd,
  output logic                thr_empty,
  output logic                tx_empty
);

  logic                hold_full;
  logic [WORD_MAX-1:0] hold_data;
  logic [WORD_MAX-1:0] frame_data;
  frame_cfg_t          frame_cfg;
  logic                take;
  logic                busy;
  logic                unused_lcr;

  assign unused_lcr = lcr[LC_W-1];

  sertx_holding i_holding (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (hold_full),
    .data    (hold_data)
  );

  sertx_framer i_framer (
    .lcr         (lcr),
    .data        (hold_data),
    .cfg         (frame_cfg),
    .data_masked (frame_data)
  );

  sertx_shifter #(
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) i_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .hold_valid (hold_full),
    .hold_data  (frame_data),
    .cfg_in     (frame_cfg),
    .brk        (lcr[LC_BRK]),
    .load       (take),
    .busy       (busy),
    .line       (txd)
  );

  assign thr_empty = ~hold_full;
  assign tx_empty  = ~hold_full & ~busy;

  // R9: transmitter-empty never claims idle while a byte waits
  a_r9_empty_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty);

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic [7:0] lcr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       txd;
  logic       thr_empty;
  logic       tx_empty;

  int checks;
  int errors;
  int tick_total;
  int div;
  bit done;

  sertx_top #(.TICKS_PER_BIT(16)) i_sertx_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .lcr       (lcr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // baud tick every fourth clock, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      div       <= 0;
      baud_tick <= 1'b0;
    end else begin
      div       <= (div == 3) ? 0 : div + 1;
      baud_tick <= (div == 3);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) tick_total <= 0;
    else if (baud_tick) tick_total <= tick_total + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_tick_count(input int t0, input int n);
    while (tick_total - t0 < n) @(negedge clk);
  endtask

  function automatic int frame_ticks(input logic [7:0] l);
    int w = 5 + int'(l[1:0]);
    int p = l[3] ? 1 : 0;
    int s = !l[2] ? 16 : (l[1:0] == 2'b00 ? 24 : 32);
    return 16 * (1 + w + p) + s;
  endfunction

  // checks every bit of a frame starting at tick t0, at mid-bit
  task automatic sample_frame(input string tag, input int t0,
                              input logic [7:0] l, input logic [7:0] d);
    int w = 5 + int'(l[1:0]);
    int ones = 0;
    int pbit;
    int stop_at;
    wait_tick_count(t0, 8);
    chk({tag, " R2 start"}, txd, 0);
    for (int i = 0; i < w; i++) begin
      wait_tick_count(t0, 16 * (1 + i) + 8);
      chk({tag, " R2/R3 data"}, txd, d[i]);
      ones += d[i];
    end
    stop_at = 16 * (1 + w);
    if (l[3]) begin
      if (l[5])      pbit = l[4] ? 0 : 1;
      else if (l[4]) pbit = ones % 2;
      else           pbit = 1 - (ones % 2);
      wait_tick_count(t0, stop_at + 8);
      chk({tag, " R4/R5 parity"}, txd, pbit);
      stop_at += 16;
    end
    wait_tick_count(t0, stop_at + 8);
    chk({tag, " R2/R3 stop"}, txd, 1);
    wait_tick_count(t0, frame_ticks(l) - 2);
    chk({tag, " R6 stop tail"}, txd, 1);
  endtask

  // writes one byte to an idle transmitter and checks the whole frame
  task automatic run_frame(input string tag, input logic [7:0] l,
                           input logic [7:0] d);
    int t0;
    int len;
    @(negedge clk);
    lcr = l;
    host_write(d);
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_total;
    sample_frame(tag, t0, l, d);
    while (tx_empty !== 1'b1) @(negedge clk);
    len = tick_total - t0;
    chk({tag, " R6 frame length"}, len, frame_ticks(l));
  endtask

  task automatic test_reset;
    chk("R1 txd", txd, 1);
    chk("R1 thr_empty", thr_empty, 1);
    chk("R1 tx_empty", tx_empty, 1);
  endtask

  task automatic test_holding_idle;
    @(negedge clk);
    lcr     = 8'h03;
    wr_en   = 1'b1;
    wr_data = 8'h5A;
    @(negedge clk);
    wr_en   = 1'b0;
    chk("R8 full after write", thr_empty, 0);
    chk("R9 busy after write", tx_empty, 0);
    @(negedge clk);
    chk("R8 taken by idle shifter", thr_empty, 1);
    chk("R9 still sending", tx_empty, 0);
    while (tx_empty !== 1'b1) @(negedge clk);
  endtask

  task automatic test_back_to_back;
    int t0;
    @(negedge clk);
    lcr = 8'h03;
    host_write(8'hC3);
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_total;
    wait_tick_count(t0, 20);
    host_write(8'h3C);
    chk("R8 held while busy", thr_empty, 0);
    chk("R9 not empty with held byte", tx_empty, 0);
    wait_tick_count(t0, frame_ticks(8'h03) - 2);
    chk("R8 held until frame end", thr_empty, 0);
    chk("R10 last stop high", txd, 1);
    wait_tick_count(t0, frame_ticks(8'h03));
    chk("R10 next start at once", txd, 0);
    chk("R10 no idle gap", tx_empty, 0);
    chk("R8 released at frame end", thr_empty, 1);
    sample_frame("R10 second", t0 + frame_ticks(8'h03), 8'h03, 8'h3C);
    while (tx_empty !== 1'b1) @(negedge clk);
  endtask

  task automatic test_break;
    int t0;
    @(negedge clk);
    lcr = 8'h43;
    repeat (2) @(negedge clk);
    chk("R7 break idle low", txd, 0);
    lcr = 8'h03;
    repeat (2) @(negedge clk);
    chk("R7 released high", txd, 1);
    host_write(8'hFF);
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_total;
    wait_tick_count(t0, 40);
    chk("R7 data one before break", txd, 1);
    lcr = 8'h43;
    repeat (2) @(negedge clk);
    chk("R7 break mid-frame", txd, 0);
    lcr = 8'h03;
    repeat (2) @(negedge clk);
    chk("R7 frame resumes", txd, 1);
    while (tx_empty !== 1'b1) @(negedge clk);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    lcr     = 8'h03;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_holding_idle();
    run_frame("8N1", 8'h03, 8'hA5);
    run_frame("5E1.5", 8'h1C, 8'hF3);
    run_frame("7O2", 8'h0E, 8'h5B);
    run_frame("6 stick even0", 8'h29, 8'h2A);
    run_frame("6 stick even1", 8'h39, 8'h2B);
    run_frame("8E2", 8'h1F, 8'h81);
    run_frame("5N2 upper ignored", 8'h04, 8'hE0);
    test_back_to_back();
    test_break();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule